// File: doc/BRIEF.md
# L1 Data Cache Maintenance Sequencer

This block is the maintenance front end of a small direct-mapped write-back data cache. Software reaches it through a narrow register port. The port offers a control word, a read-only geometry word, an enable strobe and four command registers. Two commands act on the whole cache and two act on the single line that holds a given address. A walker then visits the tag/dirty model. It raises a write-back request, with a valid/ready handshake, for every dirty line that the command must preserve, and it clears valid or dirty state once the line is done.

One control bit decides whether an invalidate throws lines away or first writes them back and then discards them. While any operation that writes back lines is running, a status bit reads as set. Any register write that arrives while the walker is active is held off with a ready signal. A fill port loads the tag model, and a probe port reports hit and dirty for any address. The data path and the refill traffic live elsewhere.

Top module: `dcache_maint_seq`

## Requirements
- R1: After reset the control word reads 0, no write-back is requested, and the probe reports a miss for every line.
- R2: Control bit 0 is a read/write disable flag. While it is set, per-line flush and per-line invalidate commands change no line and request no write-back.
- R3: A write to the enable register (select 1) clears both control bit 0 and control bit 6.
- R4: The geometry register (select 6) returns the line-length field in bits [3:0]. A line holds 16 shifted left by that field bytes.
- R5: A write to the whole-flush register (select 3) requests a write-back of every valid dirty line, in ascending set order. Afterwards every line is still valid and clean.
- R6: A write to the whole-invalidate register (select 2) starts only when data bit 0 is 1. With control bit 6 clear, it invalidates every line and requests no write-back.
- R7: With control bit 6 set, a whole invalidate or a per-line invalidate writes back each dirty target line before it invalidates that line.
- R8: Per-line commands (select 4 invalidate, select 5 flush) take a byte address in data bits [ADDR_W-1:0]. They act only when that line is valid with a matching tag. A miss completes with no effect.
- R9: Control bit 8 reads 1 while a write-back-capable operation is running. It reads 0 otherwise, including during a discard-only invalidate. Writes to bit 8 are ignored.
- R10: Register reads are always ready. Every register write is stalled (ready low) while the walker is active.
- R11: A write-back request holds its valid and address until it is accepted. The line stays dirty until that handshake.
- R12: A fill installs the addressed line as valid, with its tag and the given dirty flag. The probe then reports a hit with that dirty flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 3 | Register select: 0 control, 1 enable, 2 whole invalidate, 3 whole flush, 4 line invalidate, 5 line flush, 6 geometry |
| reg_wdata | input | DATA_W | Write data or line address |
| reg_ready | output | 1 | Access accepted this cycle |
| reg_rdata | output | DATA_W | Read data for reg_sel |
| fill_en | input | 1 | Install a line into the tag model |
| fill_addr | input | ADDR_W | Address of the line to install |
| fill_dirty | input | 1 | Dirty flag of the installed line |
| probe_addr | input | ADDR_W | Address to look up |
| probe_hit | output | 1 | Probed line is valid with matching tag |
| probe_dirty | output | 1 | Probed line hits and is dirty |
| wb_valid | output | 1 | Write-back request |
| wb_ready | input | 1 | Write-back accepted |
| wb_addr | output | ADDR_W | Line-aligned write-back address |

## Verification
A wrong walker index or a wrong tag compare shows up on the write-back port within one request. It appears as an address out of ascending order, an extra request, or a missing one, and the per-clock comparison against the expected queue catches it in the cycle of the handshake. Corrupted valid or dirty state shows up at the probe port as soon as the command finishes. A status or stall fault shows up in the first cycle after a command is accepted, as a wrong bit 8 or a write that is accepted too early.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

    typedef enum logic [2:0] {
        RSEL_CTRL       = 3'd0,
        RSEL_ENABLE     = 3'd1,
        RSEL_INV_ALL    = 3'd2,
        RSEL_FLUSH_ALL  = 3'd3,
        RSEL_INV_LINE   = 3'd4,
        RSEL_FLUSH_LINE = 3'd5,
        RSEL_BUILD      = 3'd6
    } reg_sel_e;

    localparam int CTRL_DIS_BIT   = 0;
    localparam int CTRL_IMODE_BIT = 6;
    localparam int CTRL_BUSY_BIT  = 8;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_SCAN = 2'd1,
        W_WB   = 2'd2
    } walk_state_e;

    typedef struct packed {
        logic whole;
        logic do_wb;
        logic do_inv;
    } op_kind_t;

    function automatic int line_bytes(input int len_field);
        return 16 << len_field;
    endfunction

endpackage

// File: rtl/dcm_tag_array.sv
module dcm_tag_array #(
    parameter int SETS  = 8,
    parameter int TAG_W = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_we,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             fill_dirty,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    input  logic [IDX_W-1:0] pr_idx,
    input  logic [TAG_W-1:0] pr_tag,
    output logic             pr_hit,
    output logic             pr_dirty,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_clr_valid,
    input  logic             upd_clr_dirty
);
    logic [SETS-1:0]  vld;
    logic [SETS-1:0]  drt;
    logic [TAG_W-1:0] tg [SETS];
    logic [SETS-1:0]  pr_match;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
            drt <= '0;
            for (int s = 0; s < SETS; s++) tg[s] <= '0;
        end else if (fill_we) begin
            vld[fill_idx] <= 1'b1;
            drt[fill_idx] <= fill_dirty;
            tg[fill_idx]  <= fill_tag;
        end else if (upd_en) begin
            if (upd_clr_valid) vld[upd_idx] <= 1'b0;
            if (upd_clr_dirty) drt[upd_idx] <= 1'b0;
        end
    end

    // per-set tag comparators for the probe path
    for (genvar s = 0; s < SETS; s++) begin : g_cmp
        assign pr_match[s] = vld[s] && (tg[s] == pr_tag);
    end

    assign rd_valid = vld[rd_idx];
    assign rd_dirty = drt[rd_idx];
    assign rd_tag   = tg[rd_idx];
    assign pr_hit   = pr_match[pr_idx];
    assign pr_dirty = pr_match[pr_idx] && drt[pr_idx];

endmodule

// File: rtl/dcm_walker.sv
module dcm_walker
    import dcm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SETS   = 8,
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 8,
    parameter int OFF_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  op_kind_t          kind,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic [TAG_W-1:0]  start_tag,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_valid,
    input  logic              rd_dirty,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              upd_en,
    output logic              upd_clr_valid,
    output logic              upd_clr_dirty,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [ADDR_W-1:0] wb_addr,
    output logic              busy,
    output logic              flush_busy
);
    walk_state_e      state;
    op_kind_t         op;
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] cur_tag;
    logic             hit;
    logic             need_wb;
    logic             at_end;

    always_comb begin
        hit           = rd_valid && (op.whole || (rd_tag == cur_tag));
        need_wb       = hit && rd_dirty && op.do_wb;
        at_end        = !op.whole || (idx == IDX_W'(SETS - 1));
        upd_en        = 1'b0;
        upd_clr_valid = 1'b0;
        upd_clr_dirty = 1'b0;
        case (state)
            W_SCAN: begin
                if (hit && !need_wb && op.do_inv) begin
                    upd_en        = 1'b1;
                    upd_clr_valid = 1'b1;
                    upd_clr_dirty = 1'b1;
                end
            end
            W_WB: begin
                if (wb_ready) begin
                    upd_en        = 1'b1;
                    upd_clr_dirty = 1'b1;
                    upd_clr_valid = op.do_inv;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= W_IDLE;
            op      <= '0;
            idx     <= '0;
            cur_tag <= '0;
        end else begin
            case (state)
                W_IDLE: begin
                    if (start) begin
                        op      <= kind;
                        idx     <= kind.whole ? '0 : start_idx;
                        cur_tag <= start_tag;
                        state   <= W_SCAN;
                    end
                end
                W_SCAN: begin
                    if (need_wb)     state <= W_WB;
                    else if (at_end) state <= W_IDLE;
                    else             idx   <= idx + 1'b1;
                end
                W_WB: begin
                    if (wb_ready) begin
                        if (at_end) state <= W_IDLE;
                        else begin
                            idx   <= idx + 1'b1;
                            state <= W_SCAN;
                        end
                    end
                end
                default: state <= W_IDLE;
            endcase
        end
    end

    assign rd_idx     = idx;
    assign wb_valid   = (state == W_WB);
    assign wb_addr    = {rd_tag, idx, {OFF_W{1'b0}}};
    assign busy       = (state != W_IDLE);
    assign flush_busy = busy && op.do_wb;

endmodule

// File: rtl/dcm_regs.sv
module dcm_regs
    import dcm_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int LEN_FIELD = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [2:0]        sel,
    input  logic              wbit_dis,
    input  logic              wbit_imode,
    input  logic              eng_busy,
    input  logic              flush_busy,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic              cache_dis,
    output logic              cache_imode,
    output logic              cmd_start,
    output op_kind_t          cmd_kind
);
    logic accept;

    assign ready  = !(we && eng_busy);
    assign accept = req && we && ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            cache_dis   <= 1'b0;
            cache_imode <= 1'b0;
        end else if (accept) begin
            if (sel == RSEL_CTRL) begin
                cache_dis   <= wbit_dis;
                cache_imode <= wbit_imode;
            end else if (sel == RSEL_ENABLE) begin
                cache_dis   <= 1'b0;
                cache_imode <= 1'b0;
            end
        end
    end

    always_comb begin
        cmd_start = 1'b0;
        cmd_kind  = '0;
        if (accept) begin
            case (reg_sel_e'(sel))
                RSEL_INV_ALL: if (wbit_dis) begin
                    cmd_start = 1'b1;
                    cmd_kind  = '{whole: 1'b1, do_wb: cache_imode, do_inv: 1'b1};
                end
                RSEL_FLUSH_ALL: begin
                    cmd_start = 1'b1;
                    cmd_kind  = '{whole: 1'b1, do_wb: 1'b1, do_inv: 1'b0};
                end
                RSEL_INV_LINE: if (!cache_dis) begin
                    cmd_start = 1'b1;
                    cmd_kind  = '{whole: 1'b0, do_wb: cache_imode, do_inv: 1'b1};
                end
                RSEL_FLUSH_LINE: if (!cache_dis) begin
                    cmd_start = 1'b1;
                    cmd_kind  = '{whole: 1'b0, do_wb: 1'b1, do_inv: 1'b0};
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_sel_e'(sel))
            RSEL_CTRL: begin
                rdata[CTRL_DIS_BIT]   = cache_dis;
                rdata[CTRL_IMODE_BIT] = cache_imode;
                rdata[CTRL_BUSY_BIT]  = flush_busy;
            end
            RSEL_BUILD: rdata[3:0] = 4'(LEN_FIELD);
            default: ;
        endcase
    end

endmodule

// File: rtl/dcache_maint_seq.sv
module dcache_maint_seq
    import dcm_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int SETS      = 8,
    parameter int LEN_FIELD = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              reg_ready,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_dirty,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_hit,
    output logic              probe_dirty,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [ADDR_W-1:0] wb_addr
);
    localparam int LINE_B = line_bytes(LEN_FIELD);
    localparam int OFF_W  = $clog2(LINE_B);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

    logic             eng_busy;
    logic             flush_busy;
    logic             cache_dis;
    logic             cache_imode;
    logic             cmd_start;
    op_kind_t         cmd_kind;
    logic [IDX_W-1:0] rd_idx;
    logic             rd_valid;
    logic             rd_dirty;
    logic [TAG_W-1:0] rd_tag;
    logic             upd_en;
    logic             upd_clr_valid;
    logic             upd_clr_dirty;
    logic             unused_bits;

    assign unused_bits = ^{reg_wdata, fill_addr[OFF_W-1:0], probe_addr[OFF_W-1:0]};

    dcm_regs #(
        .DATA_W    (DATA_W),
        .LEN_FIELD (LEN_FIELD)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .req         (reg_req),
        .we          (reg_we),
        .sel         (reg_sel),
        .wbit_dis    (reg_wdata[CTRL_DIS_BIT]),
        .wbit_imode  (reg_wdata[CTRL_IMODE_BIT]),
        .eng_busy    (eng_busy),
        .flush_busy  (flush_busy),
        .ready       (reg_ready),
        .rdata       (reg_rdata),
        .cache_dis   (cache_dis),
        .cache_imode (cache_imode),
        .cmd_start   (cmd_start),
        .cmd_kind    (cmd_kind)
    );

    dcm_walker #(
        .ADDR_W (ADDR_W),
        .SETS   (SETS),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W),
        .OFF_W  (OFF_W)
    ) u_walk (
        .clk           (clk),
        .rst           (rst),
        .start         (cmd_start),
        .kind          (cmd_kind),
        .start_idx     (reg_wdata[OFF_W +: IDX_W]),
        .start_tag     (reg_wdata[ADDR_W-1 -: TAG_W]),
        .rd_idx        (rd_idx),
        .rd_valid      (rd_valid),
        .rd_dirty      (rd_dirty),
        .rd_tag        (rd_tag),
        .upd_en        (upd_en),
        .upd_clr_valid (upd_clr_valid),
        .upd_clr_dirty (upd_clr_dirty),
        .wb_valid      (wb_valid),
        .wb_ready      (wb_ready),
        .wb_addr       (wb_addr),
        .busy          (eng_busy),
        .flush_busy    (flush_busy)
    );

    dcm_tag_array #(
        .SETS  (SETS),
        .TAG_W (TAG_W),
        .IDX_W (IDX_W)
    ) u_tags (
        .clk           (clk),
        .rst           (rst),
        .fill_we       (fill_en && !eng_busy),
        .fill_idx      (fill_addr[OFF_W +: IDX_W]),
        .fill_tag      (fill_addr[ADDR_W-1 -: TAG_W]),
        .fill_dirty    (fill_dirty),
        .rd_idx        (rd_idx),
        .rd_valid      (rd_valid),
        .rd_dirty      (rd_dirty),
        .rd_tag        (rd_tag),
        .pr_idx        (probe_addr[OFF_W +: IDX_W]),
        .pr_tag        (probe_addr[ADDR_W-1 -: TAG_W]),
        .pr_hit        (probe_hit),
        .pr_dirty      (probe_dirty),
        .upd_en        (upd_en),
        .upd_idx       (rd_idx),
        .upd_clr_valid (upd_clr_valid),
        .upd_clr_dirty (upd_clr_dirty)
    );

endmodule

// File: rtl/dcm_checker.sv
module dcm_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_req,
    input logic              reg_we,
    input logic [2:0]        reg_sel,
    input logic              reg_ready,
    input logic              wb_valid,
    input logic              wb_ready,
    input logic [ADDR_W-1:0] wb_addr,
    input logic              eng_busy,
    input logic              flush_busy,
    input logic              cache_dis,
    input logic              cache_imode
);
    assert_wb_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr)));

    assert_wb_flags_busy_R9: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> flush_busy);

    assert_write_stall_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_req && reg_we && eng_busy) |-> !reg_ready);

    assert_read_ready_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_req && !reg_we) |-> reg_ready);

    assert_enable_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_req && reg_we && reg_ready && reg_sel == 3'd1) |=> (!cache_dis && !cache_imode));

    assert_disabled_line_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_req && reg_we && reg_ready && cache_dis && (reg_sel == 3'd4 || reg_sel == 3'd5))
        |=> !eng_busy);
endmodule

bind dcache_maint_seq dcm_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_req     (reg_req),
    .reg_we      (reg_we),
    .reg_sel     (reg_sel),
    .reg_ready   (reg_ready),
    .wb_valid    (wb_valid),
    .wb_ready    (wb_ready),
    .wb_addr     (wb_addr),
    .eng_busy    (eng_busy),
    .flush_busy  (flush_busy),
    .cache_dis   (cache_dis),
    .cache_imode (cache_imode)
);

// File: tb/sim_dcache_maint_seq.sv
module sim_dcache_maint_seq;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int SETS   = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_req = 1'b0;
    logic              reg_we = 1'b0;
    logic [2:0]        reg_sel = 3'd0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic              reg_ready;
    logic [DATA_W-1:0] reg_rdata;
    logic              fill_en = 1'b0;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic              fill_dirty = 1'b0;
    logic [ADDR_W-1:0] probe_addr = '0;
    logic              probe_hit;
    logic              probe_dirty;
    logic              wb_valid;
    logic              wb_ready = 1'b0;
    logic [ADDR_W-1:0] wb_addr;

    dcache_maint_seq u0 (.*);

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int bp_mode = 0;
    int pat = 0;
    int cycles = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit         mv [SETS];
    bit         md [SETS];
    logic [7:0] mt [SETS];
    bit         mdis = 1'b0;
    bit         mimode = 1'b0;
    logic [ADDR_W-1:0] expq [$];

    function automatic logic [15:0] mk(input logic [7:0] tag, input int idx);
        return {tag, idx[2:0], 5'b00000};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // reference write-back stream, compared every clock
    always @(negedge clk) begin
        #2;
        pat++;
        case (bp_mode)
            0: wb_ready = 1'b1;
            1: wb_ready = pat[0];
            2: wb_ready = (pat % 3 == 0);
            default: wb_ready = 1'b0;
        endcase
        #1;
        if (!rst && wb_valid && wb_ready) begin
            if (expq.size() == 0) chk("R5 R7 spurious write-back", {16'h0, wb_addr}, 32'hFFFF_FFFF);
            else chk("R5 R7 write-back order", {16'h0, wb_addr}, {16'h0, expq.pop_front()});
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL R10 watchdog: actual %0d cycles expected completion", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic reg_write(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_req = 1'b1; reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        #1;
        while (!reg_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        reg_req = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] sel, output logic [31:0] data, output logic rdy);
        reg_req = 1'b1; reg_we = 1'b0; reg_sel = sel;
        #1;
        data = reg_rdata; rdy = reg_ready;
        reg_req = 1'b0;
    endtask

    // update the reference, then issue the write
    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        int ix;
        ix = int'(data[7:5]);
        case (sel)
            3'd0: begin mdis = data[0]; mimode = data[6]; end
            3'd1: begin mdis = 1'b0; mimode = 1'b0; end
            3'd2: if (data[0]) for (int i = 0; i < SETS; i++) begin
                if (mv[i] && md[i] && mimode) expq.push_back(mk(mt[i], i));
                mv[i] = 1'b0; md[i] = 1'b0;
            end
            3'd3: for (int i = 0; i < SETS; i++) begin
                if (mv[i] && md[i]) expq.push_back(mk(mt[i], i));
                md[i] = 1'b0;
            end
            3'd4: if (!mdis && mv[ix] && mt[ix] == data[15:8]) begin
                if (md[ix] && mimode) expq.push_back(mk(mt[ix], ix));
                mv[ix] = 1'b0; md[ix] = 1'b0;
            end
            3'd5: if (!mdis && mv[ix] && mt[ix] == data[15:8]) begin
                if (md[ix]) expq.push_back(mk(mt[ix], ix));
                md[ix] = 1'b0;
            end
            default: ;
        endcase
        reg_write(sel, data);
    endtask

    task automatic sync(input string req);
        reg_write(3'd0, {23'h0, 1'b0, 1'b0, mimode, 5'h0, mdis});
        chk({req, " pending write-backs"}, expq.size(), 0);
    endtask

    task automatic fill(input logic [7:0] tag, input int idx, input bit dirty);
        @(negedge clk);
        fill_en = 1'b1; fill_addr = mk(tag, idx); fill_dirty = dirty;
        @(negedge clk);
        fill_en = 1'b0;
        mv[idx] = 1'b1; md[idx] = dirty; mt[idx] = tag;
    endtask

    task automatic probe(input string req, input logic [15:0] addr, input bit eh, input bit ed);
        @(negedge clk);
        probe_addr = addr;
        #1;
        chk({req, " probe hit"}, probe_hit, eh);
        chk({req, " probe dirty"}, probe_dirty, ed);
    endtask

    task automatic probe_all(input string req);
        for (int i = 0; i < SETS; i++) probe(req, mk(mt[i], i), mv[i], md[i]);
    endtask

    initial begin
        logic [31:0] rd;
        logic        rdy;
        for (int i = 0; i < SETS; i++) begin mv[i] = 0; md[i] = 0; mt[i] = 8'h00; end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        reg_read(3'd0, rd, rdy);
        chk("R1 control after reset", rd, 32'h0);
        chk("R1 no write-back after reset", wb_valid, 1'b0);
        for (int i = 0; i < SETS; i++) probe("R1", mk(8'h00, i), 1'b0, 1'b0);

        // R4 geometry
        @(negedge clk);
        reg_read(3'd6, rd, rdy);
        chk("R4 line length field", rd, 32'h1);

        // R12 fills
        for (int i = 0; i < SETS; i++) fill(8'h10 + 8'(i), i, (i % 3) != 0);
        probe_all("R12");

        // R5 whole flush with back-pressure; R9 / R10 while running
        bp_mode = 1;
        wr(3'd3, 32'h1);
        reg_read(3'd0, rd, rdy);
        chk("R9 flush status during flush", rd[8], 1'b1);
        chk("R10 read ready during flush", rdy, 1'b1);
        reg_req = 1'b1; reg_we = 1'b1; reg_sel = 3'd0; reg_wdata = 32'h0;
        #1;
        chk("R10 write stalled during flush", reg_ready, 1'b0);
        reg_req = 1'b0; reg_we = 1'b0;
        sync("R5");
        probe_all("R5");
        @(negedge clk);
        reg_read(3'd0, rd, rdy);
        chk("R9 flush status clear after flush", rd[8], 1'b0);

        // R8 per-line flush: miss then hit; R11 holding the request
        bp_mode = 0;
        fill(8'h12, 2, 1'b1);
        wr(3'd5, {16'h0, mk(8'h55, 2)});
        sync("R8");
        probe("R8 line flush miss", mk(8'h12, 2), 1'b1, 1'b1);
        bp_mode = 3;
        wr(3'd5, {16'h0, mk(8'h12, 2)});
        probe_addr = mk(8'h12, 2);
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            #1;
            chk("R11 request held", wb_valid, 1'b1);
            chk("R11 address held", {16'h0, wb_addr}, {16'h0, mk(8'h12, 2)});
            chk("R11 dirty until handshake", probe_dirty, 1'b1);
            @(negedge clk);
        end
        bp_mode = 0;
        sync("R11");
        probe("R8 line flush hit", mk(8'h12, 2), 1'b1, 1'b0);

        // R8 per-line invalidate, discard mode
        fill(8'h13, 3, 1'b1);
        wr(3'd4, {16'h0, mk(8'h13, 3)});
        sync("R8");
        probe("R8 line invalidate discards", mk(8'h13, 3), 1'b0, 1'b0);

        // R7 invalidate mode set: line invalidate writes back first
        wr(3'd0, 32'h40);
        @(negedge clk);
        reg_read(3'd0, rd, rdy);
        chk("R7 mode bit readback", rd, 32'h40);
        fill(8'h14, 4, 1'b1);
        wr(3'd4, {16'h0, mk(8'h14, 4)});
        sync("R7");
        probe("R7 line invalidated after write-back", mk(8'h14, 4), 1'b0, 1'b0);

        // R9 status bit not writable
        wr(3'd0, 32'h140);
        @(negedge clk);
        reg_read(3'd0, rd, rdy);
        chk("R9 status bit ignores writes", rd, 32'h40);

        // R2 disabled cache ignores line commands
        wr(3'd0, 32'h41);
        @(negedge clk);
        reg_read(3'd0, rd, rdy);
        chk("R2 disable bit readback", rd, 32'h41);
        fill(8'h15, 5, 1'b1);
        wr(3'd5, {16'h0, mk(8'h15, 5)});
        sync("R2");
        probe("R2 line flush ignored", mk(8'h15, 5), 1'b1, 1'b1);
        wr(3'd4, {16'h0, mk(8'h15, 5)});
        sync("R2");
        probe("R2 line invalidate ignored", mk(8'h15, 5), 1'b1, 1'b1);

        // R3 enable strobe clears both bits
        wr(3'd1, 32'h0);
        @(negedge clk);
        reg_read(3'd0, rd, rdy);
        chk("R3 enable clears disable and mode", rd, 32'h0);

        // R6 whole invalidate needs data bit 0
        wr(3'd2, 32'h0);
        sync("R6");
        probe("R6 zero write no effect", mk(8'h15, 5), 1'b1, 1'b1);
        wr(3'd2, 32'h1);
        reg_read(3'd0, rd, rdy);
        chk("R9 no status on discard invalidate", rd[8], 1'b0);
        reg_req = 1'b1; reg_we = 1'b1; reg_sel = 3'd0; reg_wdata = 32'h0;
        #1;
        chk("R10 write stalled during invalidate", reg_ready, 1'b0);
        reg_req = 1'b0; reg_we = 1'b0;
        sync("R6");
        probe_all("R6");

        // R7 whole invalidate with write-back, slow acceptor
        for (int i = 0; i < SETS; i++) fill(8'h20 + 8'(i), i, (i % 2) == 0);
        wr(3'd0, 32'h40);
        bp_mode = 2;
        wr(3'd2, 32'h1);
        sync("R7");
        probe_all("R7");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule